// File: doc/BRIEF.md
# Eight-Level Prioritised Interrupt Controller

This block gathers eight interrupt request lines from peripherals and presents one interrupt output to a processor. Requests are latched into a pending register, filtered by a per-line mask and compared by a priority resolver against the set of levels already being serviced. The interrupt output goes high only when the best unmasked pending level outranks every level in service, so service routines nest by priority.

The processor answers with three acknowledge pulses. The first pulse returns a call opcode and moves the winning level from pending to in-service. The second returns the low byte of that level's vector, and the third returns the high byte. The vector table is either 4 or 8 bytes per level. Software configures the block with a two-word initialisation sequence and then issues mask writes and commands in any order. The commands cover specific and nonspecific end of interrupt, a fixed lowest level and automatic rotation. Initialisation can also select automatic end of interrupt.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset `irq_out` is 0 and `ack_data` is 0x00. `irq_out` stays 0 until an init word (address bit 0, data bit 4 = 1) has been written and then a write with address bit 1 has supplied the vector high byte.
- R2: Init word fields: bits 7:5 are the vector base, bit 3 selects level mode (0 = edge), bit 2 selects 4-byte spacing (0 = 8-byte), and bit 1 selects automatic end of interrupt. The init word clears the mask, the in-service set and all pending requests, and restores fixed priority (level 0 highest, 7 lowest).
- R3: Once initialised, every write with address bit 1 loads the mask. Mask bit i = 1 keeps line i from raising `irq_out` and from winning an acknowledge.
- R4: In edge mode, a line that rises sets its pending bit at the next clock edge. A line that stays high sets it only once, and the line must be seen low before it can set the bit again. A line that is already high at initialisation is not captured.
- R5: In level mode, the pending bit follows the line one clock later, so a line that drops before acknowledge withdraws its request.
- R6: `irq_out` is 1 exactly when the highest-priority unmasked pending level ranks above every in-service level. A level never interrupts an equal or higher level that is in service.
- R7: On the first acknowledge pulse, the winning level's in-service bit is set and its pending bit is cleared. In the following cycle `ack_data` = 0xCD.
- R8: The second pulse returns the low vector byte: {base[7:5], level, 2'b00} for 4-byte spacing, or {base[7:6], level, 3'b000} for 8-byte spacing. The third pulse returns the high byte written during initialisation.
- R9: The command byte 0x20 (address bit 0; bits 7:5 = 001, bits 4:3 = 00) clears the highest-priority in-service bit.
- R10: A command with bits 7:5 = 011 clears the in-service bit of the level given in bits 2:0. Any other in-service level is left untouched.
- R11: When automatic end of interrupt is selected, the in-service bit of the acknowledged level is cleared on the third pulse.
- R12: A command with bits 7:5 = 110 makes the level in bits 2:0 the lowest priority. The level one above it (modulo 8) becomes the highest, and the rest follow in circular order.
- R13: A command with bits 7:5 = 100 enables automatic rotation and 000 disables it. While rotation is enabled, a level cleared by a nonspecific or automatic end of interrupt becomes the lowest priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | One-cycle write strobe from the processor |
| bus_a0 | input | 1 | Register select: 0 = init word or command, 1 = vector high byte or mask |
| bus_wdata | input | 8 | Write data |
| irq_lines | input | 8 | Interrupt request lines, level 0 to level 7 |
| ack_pulse | input | 1 | One-cycle acknowledge pulse; three pulses make one acknowledge sequence |
| irq_out | output | 1 | Interrupt request to the processor |
| ack_data | output | 8 | Byte returned for the latest acknowledge pulse |

## Verification
Two functions can fall on the same clock edge. One is a new edge on a lower-priority line. The other is the first acknowledge pulse, which clears a different level's pending bit in the same register. The bench raises line 6 in the very cycle that the first pulse takes level 3. It then requires that `irq_out` stays low while level 3 is in service, that it rises after the end-of-interrupt command, and that the next acknowledge returns the vector for level 6. If the pending bit were lost or wrongly cleared, that vector would be missing or wrong.

// File: rtl/pic8_pkg.sv
package pic8_pkg;

    localparam int LVL_N = 8;
    localparam int LVL_W = $clog2(LVL_N);
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        CFG_UNSET   = 2'd0,
        CFG_WAIT_HI = 2'd1,
        CFG_READY   = 2'd2
    } cfg_state_e;

    typedef enum logic [1:0] {
        ACK_CALL = 2'd0,
        ACK_LOW  = 2'd1,
        ACK_HIGH = 2'd2
    } ack_phase_e;

    typedef enum logic [2:0] {
        OP_ROT_OFF  = 3'b000,
        OP_EOI_NS   = 3'b001,
        OP_EOI_SP   = 3'b011,
        OP_ROT_ON   = 3'b100,
        OP_SET_LOW  = 3'b110
    } op_e;

    typedef struct packed {
        logic [2:0]        vec_base;
        logic              level_mode;
        logic              space4;
        logic              auto_eoi;
        logic [BYTE_W-1:0] vec_hi;
    } cfg_t;

    typedef struct packed {
        logic             any;
        logic [LVL_W-1:0] lvl;
    } pick_t;

    // Highest-priority set bit, given the current lowest-priority level.
    function automatic pick_t pick_top(logic [LVL_N-1:0] v, logic [LVL_W-1:0] low);
        pick_t r;
        r = '0;
        for (int k = LVL_N - 1; k >= 0; k--) begin
            logic [LVL_W-1:0] l;
            l = low + LVL_W'(k + 1);
            if (v[l]) begin
                r.any = 1'b1;
                r.lvl = l;
            end
        end
        return r;
    endfunction

    // Smaller rank means higher priority.
    function automatic logic [LVL_W-1:0] rank_of(logic [LVL_W-1:0] l, logic [LVL_W-1:0] low);
        return LVL_W'(l - low - LVL_W'(1));
    endfunction

    function automatic logic [BYTE_W-1:0] vec_low(cfg_t c, logic [LVL_W-1:0] l);
        return c.space4 ? {c.vec_base, l, 2'b00} : {c.vec_base[2:1], l, 3'b000};
    endfunction

endpackage

// File: rtl/pic8_capture.sv
module pic8_capture #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         level_mode,
    input  logic [N-1:0] lines,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    // armed[i] is set while line i was low in the previous cycle
    logic [N-1:0] armed;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            pend  <= '0;
            armed <= '0;
        end else begin
            armed <= ~lines;
            if (level_mode)
                pend <= lines & ~clr;
            else
                pend <= (pend | (lines & armed)) & ~clr;
        end
    end
endmodule

// File: rtl/pic8_resolver.sv
module pic8_resolver
    import pic8_pkg::*;
(
    input  logic [LVL_N-1:0] req,
    input  logic [LVL_N-1:0] isr,
    input  logic [LVL_W-1:0] low,
    output pick_t            req_pick,
    output pick_t            isr_pick,
    output logic             fire
);
    always_comb begin
        req_pick = pick_top(req, low);
        isr_pick = pick_top(isr, low);
        fire     = req_pick.any &&
                   (!isr_pick.any ||
                    (rank_of(req_pick.lvl, low) < rank_of(isr_pick.lvl, low)));
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic8_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CALL_OP = 8'hCD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_a0,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic [LVL_N-1:0]  irq_lines,
    input  logic              ack_pulse,
    output logic              irq_out,
    output logic [BYTE_W-1:0] ack_data
);
    cfg_t              cfg;
    cfg_state_e        cst;
    ack_phase_e        ph;
    logic [LVL_N-1:0]  imr, isr, irr;
    logic [LVL_W-1:0]  lowp, rot_to, ack_lvl;
    logic              rot_auto, ack_hit;
    logic [LVL_N-1:0]  isr_set, isr_clr, irr_clr;
    pick_t             rp, ip;
    logic              fire;

    wire   ready   = (cst == CFG_READY);
    wire   wr_init = bus_wr && !bus_a0 && bus_wdata[4];
    wire   wr_hi   = bus_wr && bus_a0;
    wire   wr_cmd  = bus_wr && !bus_a0 && !bus_wdata[4] && !bus_wdata[3] && ready;
    wire   ack_go  = ack_pulse && ready;
    op_e   op;
    assign op = op_e'(bus_wdata[7:5]);

    pic8_capture #(.N(LVL_N)) u_cap (
        .clk        (clk),
        .rst        (rst),
        .flush      (wr_init),
        .level_mode (cfg.level_mode),
        .lines      (irq_lines),
        .clr        (irr_clr),
        .pend       (irr)
    );

    pic8_resolver u_res (
        .req      (irr & ~imr),
        .isr      (isr),
        .low      (lowp),
        .req_pick (rp),
        .isr_pick (ip),
        .fire     (fire)
    );

    always_comb begin
        isr_set = '0;
        isr_clr = '0;
        irr_clr = '0;
        rot_to  = lowp;
        if (ack_go && ph == ACK_CALL && rp.any) begin
            isr_set[rp.lvl] = 1'b1;
            irr_clr[rp.lvl] = 1'b1;
        end
        if (ack_go && ph == ACK_HIGH && cfg.auto_eoi && ack_hit) begin
            isr_clr[ack_lvl] = 1'b1;
            if (rot_auto) rot_to = ack_lvl;
        end
        if (wr_cmd) begin
            case (op)
                OP_EOI_NS: if (ip.any) begin
                    isr_clr[ip.lvl] = 1'b1;
                    if (rot_auto) rot_to = ip.lvl;
                end
                OP_EOI_SP:  isr_clr[bus_wdata[LVL_W-1:0]] = 1'b1;
                OP_SET_LOW: rot_to = bus_wdata[LVL_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '0;
            cst      <= CFG_UNSET;
            ph       <= ACK_CALL;
            imr      <= '0;
            isr      <= '0;
            lowp     <= LVL_W'(LVL_N - 1);
            rot_auto <= 1'b0;
            ack_lvl  <= '0;
            ack_hit  <= 1'b0;
            ack_data <= '0;
        end else if (wr_init) begin
            cfg.vec_base   <= bus_wdata[7:5];
            cfg.level_mode <= bus_wdata[3];
            cfg.space4     <= bus_wdata[2];
            cfg.auto_eoi   <= bus_wdata[1];
            cst            <= CFG_WAIT_HI;
            ph             <= ACK_CALL;
            imr            <= '0;
            isr            <= '0;
            lowp           <= LVL_W'(LVL_N - 1);
            rot_auto       <= 1'b0;
        end else begin
            if (wr_hi) begin
                if (cst == CFG_WAIT_HI) begin
                    cfg.vec_hi <= bus_wdata;
                    cst        <= CFG_READY;
                end else if (ready) begin
                    imr <= bus_wdata;
                end
            end
            if (wr_cmd && op == OP_ROT_ON)  rot_auto <= 1'b1;
            if (wr_cmd && op == OP_ROT_OFF) rot_auto <= 1'b0;
            isr  <= (isr | isr_set) & ~isr_clr;
            lowp <= rot_to;
            if (ack_go) begin
                case (ph)
                    ACK_CALL: begin
                        ack_data <= CALL_OP;
                        ack_lvl  <= rp.any ? rp.lvl : LVL_W'(LVL_N - 1);
                        ack_hit  <= rp.any;
                        ph       <= ACK_LOW;
                    end
                    ACK_LOW: begin
                        ack_data <= vec_low(cfg, ack_lvl);
                        ph       <= ACK_HIGH;
                    end
                    ACK_HIGH: begin
                        ack_data <= cfg.vec_hi;
                        ph       <= ACK_CALL;
                    end
                    default: ph <= ACK_CALL;
                endcase
            end
        end
    end

    assign irq_out = ready && fire;

endmodule

// File: rtl/pic8_chk.sv
module pic8_chk
    import pic8_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CALL_OP = 8'hCD
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              ack_pulse,
    input logic              irq_out,
    input logic [BYTE_W-1:0] ack_data,
    input logic              ready,
    input ack_phase_e        ph,
    input logic [LVL_N-1:0]  isr,
    input logic [LVL_N-1:0]  irr,
    input logic [LVL_N-1:0]  imr,
    input logic              req_any,
    input logic [LVL_W-1:0]  req_lvl,
    input logic [LVL_W-1:0]  ack_lvl,
    input logic              auto_eoi
);
    AST_IRQ_NEEDS_INIT: assert property (@(posedge clk) disable iff (rst)
        !ready |-> !irq_out); // R1

    AST_IRQ_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> ((irr & ~imr) != '0)); // R3

    AST_CALL_FIRST: assert property (@(posedge clk) disable iff (rst)
        (ack_pulse && ready && ph == ACK_CALL && !bus_wr) |=> (ack_data == CALL_OP)); // R7

    AST_ISR_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (ack_pulse && ready && ph == ACK_CALL && req_any && !bus_wr)
        |=> (isr[$past(req_lvl)] && !irr[$past(req_lvl)])); // R7

    AST_AUTO_EOI_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (ack_pulse && ready && ph == ACK_HIGH && auto_eoi && !bus_wr)
        |=> !isr[$past(ack_lvl)]); // R11
endmodule

bind prio_irq_ctrl pic8_chk #(.CALL_OP(CALL_OP)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .ack_pulse (ack_pulse),
    .irq_out   (irq_out),
    .ack_data  (ack_data),
    .ready     (ready),
    .ph        (ph),
    .isr       (isr),
    .irr       (irr),
    .imr       (imr),
    .req_any   (rp.any),
    .req_lvl   (rp.lvl),
    .ack_lvl   (ack_lvl),
    .auto_eoi  (cfg.auto_eoi)
);

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_a0 = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] irq_lines = 8'h00;
    logic       ack_pulse = 1'b0;
    logic       irq_out;
    logic [7:0] ack_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    prio_irq_ctrl u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_a0(bus_a0),
        .bus_wdata(bus_wdata), .irq_lines(irq_lines), .ack_pulse(ack_pulse),
        .irq_out(irq_out), .ack_data(ack_data)
    );

    localparam logic [7:0] HI = 8'h3A;
    localparam logic [7:0] W_EDGE4 = 8'hB4; // base 101, 4-byte, edge
    // {lines, mask, expected level (FF = no interrupt)}
    localparam logic [23:0] VEC [7] = '{
        {8'h84, 8'h00, 8'd2}, {8'hF0, 8'h10, 8'd5}, {8'h01, 8'h00, 8'd0},
        {8'h80, 8'h00, 8'd7}, {8'h0C, 8'h04, 8'd3}, {8'h22, 8'h02, 8'd5},
        {8'h40, 8'h40, 8'hFF}
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(logic a0, logic [7:0] d);
        bus_wr = 1'b1; bus_a0 = a0; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic ack(output logic [7:0] b);
        ack_pulse = 1'b1;
        step();
        ack_pulse = 1'b0;
        b = ack_data;
    endtask

    task automatic ack3(string req, logic [7:0] lo_exp);
        logic [7:0] b;
        ack(b); chk({req, " call"}, b, 8'hCD);
        ack(b); chk({req, " low"}, b, lo_exp);
        ack(b); chk({req, " high"}, b, HI);
    endtask

    task automatic init(logic [7:0] w1);
        irq_lines = 8'h00;
        wr(1'b0, w1);
        wr(1'b1, HI);
    endtask

    function automatic logic [7:0] low4(logic [2:0] l);
        return {3'b101, l, 2'b00};
    endfunction

    initial begin
        logic [7:0] b;
        step(); step(); step();
        rst = 1'b0;
        step();
        chk("R1 reset irq", {7'd0, irq_out}, 8'h00);
        chk("R1 reset data", ack_data, 8'h00);
        irq_lines = 8'h01; step(); step();
        chk("R1 no irq before init", {7'd0, irq_out}, 8'h00);

        // Table walk: R3 mask, R6 fixed order, R7/R8 vectors
        foreach (VEC[i]) begin
            init(W_EDGE4);
            wr(1'b1, VEC[i][15:8]);
            irq_lines = VEC[i][23:16];
            step();
            if (VEC[i][7:0] == 8'hFF) begin
                chk("R3 masked line silent", {7'd0, irq_out}, 8'h00);
            end else begin
                chk("R6 irq raised", {7'd0, irq_out}, 8'h01);
                ack3("R8 R7 table", low4(VEC[i][2:0]));
            end
        end

        // R2 init clears; R4 line high at init not captured
        irq_lines = 8'h08;
        wr(1'b0, W_EDGE4); wr(1'b1, HI); step();
        chk("R4 high at init ignored", {7'd0, irq_out}, 8'h00);

        // R6 nesting and R9 nonspecific EOI
        init(W_EDGE4);
        irq_lines = 8'h20; step();
        ack3("R7 level5", low4(3'd5));
        irq_lines = 8'h60; step();
        chk("R6 lower blocked", {7'd0, irq_out}, 8'h00);
        irq_lines = 8'h64; step();
        chk("R6 higher nests", {7'd0, irq_out}, 8'h01);
        ack3("R7 level2", low4(3'd2));
        wr(1'b0, 8'h20);
        chk("R9 first EOI clears level2 only", {7'd0, irq_out}, 8'h00);
        wr(1'b0, 8'h20);
        chk("R9 second EOI clears level5", {7'd0, irq_out}, 8'h01);

        // R10 specific EOI
        init(W_EDGE4);
        irq_lines = 8'h08; step();
        ack3("R7 level3", low4(3'd3));
        irq_lines = 8'h48; step();
        wr(1'b0, 8'h64);
        chk("R10 other level untouched", {7'd0, irq_out}, 8'h00);
        wr(1'b0, 8'h63);
        chk("R10 named level cleared", {7'd0, irq_out}, 8'h01);

        // R11 automatic EOI
        init(W_EDGE4 | 8'h02);
        irq_lines = 8'h82; step();
        ack(b); chk("R11 call", b, 8'hCD);
        chk("R11 level7 blocked", {7'd0, irq_out}, 8'h00);
        ack(b); ack(b);
        chk("R11 cleared at third pulse", {7'd0, irq_out}, 8'h01);

        // R2/R8 8-byte spacing, base bit 5 unused
        init(8'hF0);
        irq_lines = 8'h20; step();
        ack3("R8 8-byte spacing", 8'hE8);

        // R4 edge re-arm
        init(W_EDGE4);
        irq_lines = 8'h10; step();
        ack3("R4 first edge", low4(3'd4));
        wr(1'b0, 8'h20); step();
        chk("R4 held line not re-captured", {7'd0, irq_out}, 8'h00);
        irq_lines = 8'h00; step();
        irq_lines = 8'h10; step();
        chk("R4 new edge captured", {7'd0, irq_out}, 8'h01);

        // R5 level mode
        init(W_EDGE4 | 8'h08);
        irq_lines = 8'h08; step();
        chk("R5 level request", {7'd0, irq_out}, 8'h01);
        irq_lines = 8'h00; step();
        chk("R5 level withdrawn", {7'd0, irq_out}, 8'h00);

        // R12 specific rotation: lowest = 3, so 4 beats 0
        init(W_EDGE4);
        wr(1'b0, 8'hC3);
        irq_lines = 8'h11; step();
        ack3("R12 level4 wins", low4(3'd4));

        // R13 automatic rotation
        init(W_EDGE4);
        wr(1'b0, 8'h80);
        irq_lines = 8'h06; step();
        ack3("R13 level1 first", low4(3'd1));
        wr(1'b0, 8'h20);
        irq_lines = 8'h00; step();
        irq_lines = 8'h06; step();
        ack3("R13 level2 after rotation", low4(3'd2));

        // Same-cycle: new edge on 6 while first pulse takes 3
        init(W_EDGE4);
        irq_lines = 8'h08; step();
        irq_lines = 8'h48;
        ack(b); chk("R7 call same cycle", b, 8'hCD);
        ack(b); chk("R8 low level3", b, low4(3'd3));
        ack(b);
        chk("R6 level6 waits", {7'd0, irq_out}, 8'h00);
        wr(1'b0, 8'h20);
        chk("R4 level6 capture kept", {7'd0, irq_out}, 8'h01);
        ack3("R8 level6", low4(3'd6));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule